// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block runs a whole serial-memory transaction on its own by stepping an I2C master controller through its register interface. A single start strobe carries a 7-bit device address, an internal (word) address of zero to four bytes, a byte count and an operation. The operation is a memory write, a memory read or a device probe. The sequencer writes the controller's data and control registers one phase at a time. After each phase it polls the controller until the expected status code appears.

Each phase has its own status code to expect. The first phase that shows any other code stops the remaining data phases. A phase whose interrupt flag never rises within the poll budget does the same. A stop condition is always issued afterwards. The outcome is one 32-bit diagnostic word: error class in the top byte, then the controller's control readback, then the status seen, then the status that was expected. A value of zero means success.

Write data enters through a valid/ready byte handshake. Read data leaves as one-cycle byte strobes. A busy flag, a done pulse and the held result word complete the interface.

Top module: `i2cseq_engine`

## Requirements
- R1: A write (op 0) issues START with control 0x60 and expects status 0x08. It then sends the device address with bit 0 clear and expects 0x18. Next come the internal-address bytes, and then the data bytes, each expecting 0x28. Each byte is sent as a data-register write (reg_sel 0) followed by control 0x40 (reg_sel 1).
- R2: Internal-address bytes go out most-significant byte first. An `ia_len` larger than ALEN_MAX is treated as ALEN_MAX, so only the low ALEN_MAX bytes of `ia` are sent.
- R3: A read (op 1) sends START, the write address and the internal address as in R1. It then issues a repeated START (control 0x60, expect 0x10) with no stop control write in between. After that it sends the device address with bit 0 set and expects 0x40.
- R4: In a read, every received byte except the last is requested with control 0x44 and expects 0x50. The last byte is requested with control 0x40 and expects 0x58. Each good byte appears on `rdat` with a one-cycle `rdat_valid`.
- R5: A probe (op 2 or 3) issues START (0x08), then the address with bit 0 set (0x40), then one byte request with control 0x40 that expects 0x58, then the stop.
- R6: The result packs {class[31:24], control readback[23:16], status[15:8], expected status[7:0]}. It is zero when every phase matched and the bus returned to idle status 0xF8.
- R7: A phase whose status differs from its expected code gives class 1. No further phase is issued; the stop control write follows at once.
- R8: A phase whose flag has not risen after POLL_LIMIT polls, spaced POLL_GAP cycles apart, gives class 2. It carries the control readback and status seen at the last poll, and the transaction goes to the stop.
- R9: Every transaction ends with stop control 0x50 and a wait for status 0xF8. If that wait times out, the result becomes {2, control, status, 0xF8}, but only when no earlier error was recorded.
- R10: After reset, busy, done and result are all zero. A start while busy is ignored. Done is a one-cycle pulse that comes with busy low, and the result changes only in the done cycle.
- R11: Each write data byte is taken on a cycle where `wdat_valid` and `wdat_ready` are both high. That byte is written to the data register on the next cycle, and bytes keep their arrival order.
- R12: A read with a byte count of zero ends with the stop directly after the read-address phase. A write with no address bytes and no data ends with the stop directly after the write-address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| op | input | 2 | 0 write, 1 read, 2 or 3 probe |
| dev_addr | input | 7 | Device address |
| ia | input | 8*ALEN_MAX | Internal address, low bytes used |
| ia_len | input | clog2(ALEN_MAX+1) | Internal address length in bytes |
| byte_cnt | input | CNT_W | Data bytes to write or read |
| wdat | input | 8 | Write data byte |
| wdat_valid | input | 1 | Write data byte present |
| wdat_ready | output | 1 | Sequencer takes a write byte |
| rdat | output | 8 | Received byte |
| rdat_valid | output | 1 | Received byte strobe |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished, result valid |
| result | output | 32 | Packed diagnostic word |
| reg_wr | output | 1 | Controller register write strobe |
| reg_sel | output | 1 | 0 data register, 1 control register |
| reg_wdata | output | 8 | Controller register write value |
| ctl_flag | input | 1 | Controller interrupt flag |
| ctl_status | input | 8 | Controller status code |
| ctl_ctrl | input | 8 | Controller control readback |
| ctl_rdata | input | 8 | Controller received data |

## Verification
On every cycle, the embedded assertions check the handshake rules. These are the done/busy exclusion, the result holding between done pulses, register writes occurring only while busy, and an accepted write byte reaching the data register on the next cycle. The poll counter is also checked: it never passes its limit, and a new wait never starts while one is still running. The phase order, the expected codes per phase, the address byte order, the ACK/NAK choice on the last read byte, and the error-class precedence between a phase failure and a stop timeout can only be shown by the scenarios. In those, a modelled controller answers with scripted status codes and a scoreboard compares every register write and every result word.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

   // status codes reported by the controller
   localparam logic [7:0] ST_BEGIN_OK  = 8'h08;
   localparam logic [7:0] ST_RBEGIN_OK = 8'h10;
   localparam logic [7:0] ST_AW_ACK    = 8'h18;
   localparam logic [7:0] ST_TX_ACK    = 8'h28;
   localparam logic [7:0] ST_AR_ACK    = 8'h40;
   localparam logic [7:0] ST_RX_ACK    = 8'h50;
   localparam logic [7:0] ST_RX_NAK    = 8'h58;
   localparam logic [7:0] ST_BUS_IDLE  = 8'hF8;

   // control register bits
   localparam logic [7:0] CB_ACK   = 8'h04;
   localparam logic [7:0] CB_STOP  = 8'h10;
   localparam logic [7:0] CB_START = 8'h20;
   localparam logic [7:0] CB_EN    = 8'h40;

   localparam logic [7:0] CTL_BEGIN = CB_EN | CB_START;
   localparam logic [7:0] CTL_XFER  = CB_EN;
   localparam logic [7:0] CTL_RXACK = CB_EN | CB_ACK;
   localparam logic [7:0] CTL_HALT  = CB_EN | CB_STOP;

   localparam logic [7:0] ERR_MISMATCH = 8'd1;
   localparam logic [7:0] ERR_TIMEOUT  = 8'd2;

   typedef enum logic [2:0] {
      PH_START, PH_ADDRW, PH_IA, PH_DATA, PH_RSTART, PH_ADDRR, PH_RECV
   } phase_e;

   function automatic logic [31:0] pack_diag(input logic [7:0] cls, input logic [7:0] ctl,
                                             input logic [7:0] st, input logic [7:0] exp_st);
      return {cls, ctl, st, exp_st};
   endfunction

endpackage

// File: rtl/i2cseq_expect.sv
module i2cseq_expect
   import i2cseq_pkg::*;
(
   input  phase_e     ph,
   input  logic       rx_ack,
   output logic [7:0] exp_st,
   output logic [7:0] ctl_code
);

   always_comb begin
      exp_st   = ST_TX_ACK;
      ctl_code = CTL_XFER;
      case (ph)
         PH_START:  begin exp_st = ST_BEGIN_OK;  ctl_code = CTL_BEGIN; end
         PH_RSTART: begin exp_st = ST_RBEGIN_OK; ctl_code = CTL_BEGIN; end
         PH_ADDRW:  exp_st = ST_AW_ACK;
         PH_IA,
         PH_DATA:   exp_st = ST_TX_ACK;
         PH_ADDRR:  exp_st = ST_AR_ACK;
         PH_RECV: begin
            exp_st   = rx_ack ? ST_RX_ACK : ST_RX_NAK;
            ctl_code = rx_ack ? CTL_RXACK : CTL_XFER;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/i2cseq_addr_mux.sv
module i2cseq_addr_mux #(
   parameter int ALEN_MAX = 4,
   localparam int IA_W   = 8 * ALEN_MAX,
   localparam int ALEN_W = $clog2(ALEN_MAX + 1)
) (
   input  logic [IA_W-1:0]   ia,
   input  logic [ALEN_W-1:0] idx,
   output logic [7:0]        byte_o
);

   generate
      if (ALEN_MAX == 1) begin : g_single
         logic unused_idx;
         assign unused_idx = ^idx;
         assign byte_o = ia[7:0];
      end else begin : g_multi
         logic [7:0] lane [ALEN_MAX];
         for (genvar g = 0; g < ALEN_MAX; g++) begin : g_lane
            assign lane[g] = ia[8*g +: 8];
         end
         always_comb begin
            byte_o = 8'h00;
            for (int k = 0; k < ALEN_MAX; k++)
               if (idx == ALEN_W'(k)) byte_o = lane[k];
         end
      end
   endgenerate

endmodule

// File: rtl/i2cseq_poll.sv
module i2cseq_poll
   import i2cseq_pkg::*;
#(
   parameter int POLL_GAP   = 2000,
   parameter int POLL_LIMIT = 1000,
   localparam int GAP_W = (POLL_GAP > 2) ? $clog2(POLL_GAP) : 1,
   localparam int LIM_W = $clog2(POLL_LIMIT + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       stop_mode,
   input  logic       flag,
   input  logic [7:0] status,
   output logic       hit,
   output logic       expire,
   output logic       active
);

   generate
      if (POLL_GAP < 2) begin : g_bad_gap
         $error("POLL_GAP must be at least 2");
      end
      if (POLL_LIMIT < 1) begin : g_bad_lim
         $error("POLL_LIMIT must be at least 1");
      end
   endgenerate

   logic             mode_q;
   logic [GAP_W-1:0] gap_q;
   logic [LIM_W-1:0] cnt_q;
   logic             tick, cond;

   assign tick   = active && (gap_q == GAP_W'(POLL_GAP - 1));
   assign cond   = mode_q ? (status == ST_BUS_IDLE) : flag;
   assign hit    = tick && cond;
   assign expire = tick && !cond && (cnt_q == LIM_W'(POLL_LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         mode_q <= 1'b0;
         gap_q  <= '0;
         cnt_q  <= '0;
      end else if (go) begin
         active <= 1'b1;
         mode_q <= stop_mode;
         gap_q  <= '0;
         cnt_q  <= '0;
      end else if (active) begin
         if (tick) begin
            gap_q <= '0;
            if (hit || expire) active <= 1'b0;
            else               cnt_q  <= cnt_q + 1'b1;
         end else begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   // R8
   poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt_q < LIM_W'(POLL_LIMIT)));

   // R8
   go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !active);

endmodule

// File: rtl/i2cseq_engine.sv
module i2cseq_engine
   import i2cseq_pkg::*;
#(
   parameter int ALEN_MAX   = 4,
   parameter int CNT_W      = 16,
   parameter int POLL_GAP   = 2000,
   parameter int POLL_LIMIT = 1000,
   localparam int IA_W   = 8 * ALEN_MAX,
   localparam int ALEN_W = $clog2(ALEN_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [6:0]        dev_addr,
   input  logic [IA_W-1:0]   ia,
   input  logic [ALEN_W-1:0] ia_len,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic [7:0]        wdat,
   input  logic              wdat_valid,
   output logic              wdat_ready,
   output logic [7:0]        rdat,
   output logic              rdat_valid,
   output logic              busy,
   output logic              done,
   output logic [31:0]       result,
   output logic              reg_wr,
   output logic              reg_sel,
   output logic [7:0]        reg_wdata,
   input  logic              ctl_flag,
   input  logic [7:0]        ctl_status,
   input  logic [7:0]        ctl_ctrl,
   input  logic [7:0]        ctl_rdata
);

   generate
      if (ALEN_MAX < 1 || ALEN_MAX > 4) begin : g_bad_alen
         $error("ALEN_MAX must be 1 to 4");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be positive");
      end
   endgenerate

   typedef enum logic [3:0] {
      S_IDLE, S_BEGIN, S_PUT_DATA, S_PUT_CTL, S_FETCH, S_PULL,
      S_WAIT, S_HALT, S_HALT_WAIT, S_FINISH
   } state_e;

   state_e             st;
   phase_e             ph, ph_n;
   logic [1:0]         op_q;
   logic [6:0]         dev_q;
   logic [IA_W-1:0]    ia_q;
   logic [ALEN_W-1:0]  ia_left, ia_idx;
   logic [CNT_W-1:0]   cnt_left;
   logic               rx_ack_q;
   logic [7:0]         tx_byte, byte_n, ia_byte;
   logic [31:0]        err_q;
   logic               stop_n;
   logic [7:0]         exp_st, ctl_code;
   logic               poll_go, poll_stop, poll_hit, poll_expire, poll_active;
   logic               is_read, is_probe;

   assign is_read  = (op_q == 2'd1);
   assign is_probe = op_q[1];
   assign busy       = (st != S_IDLE);
   assign wdat_ready = (st == S_FETCH);
   assign ia_idx     = ia_left - 1'b1;

   i2cseq_expect u_expect (
      .ph       (ph),
      .rx_ack   (rx_ack_q),
      .exp_st   (exp_st),
      .ctl_code (ctl_code)
   );

   i2cseq_addr_mux #(.ALEN_MAX(ALEN_MAX)) u_amux (
      .ia     (ia_q),
      .idx    (ia_idx),
      .byte_o (ia_byte)
   );

   assign poll_go   = (st == S_BEGIN) || (st == S_PUT_CTL) || (st == S_PULL) || (st == S_HALT);
   assign poll_stop = (st == S_HALT);

   i2cseq_poll #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_poll (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (poll_go),
      .stop_mode (poll_stop),
      .flag      (ctl_flag),
      .status    (ctl_status),
      .hit       (poll_hit),
      .expire    (poll_expire),
      .active    (poll_active)
   );

   // phase that follows a matched status
   always_comb begin
      ph_n   = ph;
      stop_n = 1'b0;
      case (ph)
         PH_START: ph_n = is_probe ? PH_ADDRR : PH_ADDRW;
         PH_ADDRW, PH_IA: begin
            if (ia_left != '0)          ph_n = PH_IA;
            else if (is_read)           ph_n = PH_RSTART;
            else if (cnt_left != '0)    ph_n = PH_DATA;
            else                        stop_n = 1'b1;
         end
         PH_DATA: begin
            if (cnt_left != '0) ph_n = PH_DATA;
            else                stop_n = 1'b1;
         end
         PH_RSTART: ph_n = PH_ADDRR;
         PH_ADDRR, PH_RECV: begin
            if (cnt_left != '0) ph_n = PH_RECV;
            else                stop_n = 1'b1;
         end
         default: stop_n = 1'b1;
      endcase
   end

   always_comb begin
      case (ph_n)
         PH_ADDRW: byte_n = {dev_q, 1'b0};
         PH_ADDRR: byte_n = {dev_q, 1'b1};
         default:  byte_n = ia_byte;
      endcase
   end

   function automatic state_e entry_state(input phase_e p);
      case (p)
         PH_START, PH_RSTART: return S_BEGIN;
         PH_DATA:             return S_FETCH;
         PH_RECV:             return S_PULL;
         default:             return S_PUT_DATA;
      endcase
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         ph         <= PH_START;
         op_q       <= 2'd0;
         dev_q      <= 7'd0;
         ia_q       <= '0;
         ia_left    <= '0;
         cnt_left   <= '0;
         rx_ack_q   <= 1'b0;
         tx_byte    <= 8'h00;
         err_q      <= 32'h0;
         result     <= 32'h0;
         done       <= 1'b0;
         rdat       <= 8'h00;
         rdat_valid <= 1'b0;
         reg_wr     <= 1'b0;
         reg_sel    <= 1'b0;
         reg_wdata  <= 8'h00;
      end else begin
         done       <= 1'b0;
         rdat_valid <= 1'b0;
         reg_wr     <= 1'b0;
         case (st)
            S_IDLE: begin
               if (start) begin
                  op_q     <= op;
                  dev_q    <= dev_addr;
                  ia_q     <= ia;
                  ia_left  <= (ia_len > ALEN_W'(ALEN_MAX)) ? ALEN_W'(ALEN_MAX) : ia_len;
                  cnt_left <= op[1] ? CNT_W'(1) : byte_cnt;
                  err_q    <= 32'h0;
                  ph       <= PH_START;
                  st       <= S_BEGIN;
               end
            end
            S_BEGIN, S_PUT_CTL, S_PULL: begin
               reg_wr    <= 1'b1;
               reg_sel   <= 1'b1;
               reg_wdata <= ctl_code;
               st        <= S_WAIT;
            end
            S_PUT_DATA: begin
               reg_wr    <= 1'b1;
               reg_sel   <= 1'b0;
               reg_wdata <= tx_byte;
               st        <= S_PUT_CTL;
            end
            S_FETCH: begin
               if (wdat_valid) begin
                  reg_wr    <= 1'b1;
                  reg_sel   <= 1'b0;
                  reg_wdata <= wdat;
                  st        <= S_PUT_CTL;
               end
            end
            S_WAIT: begin
               if (poll_expire) begin
                  err_q <= pack_diag(ERR_TIMEOUT, ctl_ctrl, ctl_status, exp_st);
                  st    <= S_HALT;
               end else if (poll_hit) begin
                  if (ctl_status != exp_st) begin
                     err_q <= pack_diag(ERR_MISMATCH, ctl_ctrl, ctl_status, exp_st);
                     st    <= S_HALT;
                  end else begin
                     if (ph == PH_RECV) begin
                        rdat       <= ctl_rdata;
                        rdat_valid <= 1'b1;
                     end
                     if (stop_n) begin
                        st <= S_HALT;
                     end else begin
                        ph      <= ph_n;
                        st      <= entry_state(ph_n);
                        tx_byte <= byte_n;
                        if (ph_n == PH_IA) ia_left <= ia_left - 1'b1;
                        if (ph_n == PH_DATA || ph_n == PH_RECV) begin
                           cnt_left <= cnt_left - 1'b1;
                           rx_ack_q <= (cnt_left > CNT_W'(1));
                        end
                     end
                  end
               end
            end
            S_HALT: begin
               reg_wr    <= 1'b1;
               reg_sel   <= 1'b1;
               reg_wdata <= CTL_HALT;
               st        <= S_HALT_WAIT;
            end
            S_HALT_WAIT: begin
               if (poll_expire) begin
                  if (err_q == 32'h0)
                     err_q <= pack_diag(ERR_TIMEOUT, ctl_ctrl, ctl_status, ST_BUS_IDLE);
                  st <= S_FINISH;
               end else if (poll_hit) begin
                  st <= S_FINISH;
               end
            end
            S_FINISH: begin
               result <= err_q;
               done   <= 1'b1;
               st     <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

   // R10
   bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> busy);

   // R11
   byte_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wdat_valid && wdat_ready) |=> (reg_wr && !reg_sel));

   // R4
   rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdat_valid |-> busy);

   // R9
   finish_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !poll_active);

endmodule

// File: tb/i2cseq_engine_tb.sv
module i2cseq_engine_tb;

   localparam int GAP = 3;
   localparam int LIM = 6;
   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [6:0]  dev_addr = 7'd0;
   logic [31:0] ia = 32'h0;
   logic [2:0]  ia_len = 3'd0;
   logic [15:0] byte_cnt = 16'd0;
   logic [7:0]  wdat = 8'h00;
   logic        wdat_valid = 1'b0;
   logic        wdat_ready;
   logic [7:0]  rdat;
   logic        rdat_valid, busy, done;
   logic [31:0] result;
   logic        reg_wr, reg_sel;
   logic [7:0]  reg_wdata;
   logic        ctl_flag;
   logic [7:0]  ctl_status, ctl_last, ctl_ctrl, ctl_rdata;

   always #2.5 clk = ~clk;

   i2cseq_engine #(.ALEN_MAX(4), .CNT_W(16), .POLL_GAP(GAP), .POLL_LIMIT(LIM)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dev_addr(dev_addr),
      .ia(ia), .ia_len(ia_len), .byte_cnt(byte_cnt), .wdat(wdat),
      .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .rdat(rdat),
      .rdat_valid(rdat_valid), .busy(busy), .done(done), .result(result),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .ctl_flag(ctl_flag), .ctl_status(ctl_status), .ctl_ctrl(ctl_ctrl),
      .ctl_rdata(ctl_rdata)
   );

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;
   string cur_req = "R1";

   logic [8:0]  wexp_q[$];
   logic [31:0] res_q[$];
   logic [7:0]  rd_q[$];
   logic [7:0]  resp_q[$];
   logic [7:0]  rx_q[$];
   logic [7:0]  wq[$];
   bit          stop_stuck = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // controller model
   int lat_cnt = 0;
   int stop_cnt = 0;
   logic [7:0] pend_st = 8'h00;
   assign ctl_ctrl = ctl_last | (ctl_flag ? 8'h08 : 8'h00);

   always @(posedge clk) begin
      if (!rst_n) begin
         ctl_flag   <= 1'b0;
         ctl_status <= 8'hF8;
         ctl_last   <= 8'h00;
         ctl_rdata  <= 8'h00;
         lat_cnt    = 0;
         stop_cnt   = 0;
      end else begin
         if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
               ctl_flag   <= 1'b1;
               ctl_status <= pend_st;
               if ((pend_st == 8'h50 || pend_st == 8'h58) && rx_q.size() > 0)
                  ctl_rdata <= rx_q.pop_front();
            end
         end
         if (stop_cnt > 0) begin
            stop_cnt--;
            if (stop_cnt == 0 && !stop_stuck) ctl_status <= 8'hF8;
         end
         if (reg_wr && reg_sel) begin
            ctl_last <= reg_wdata;
            ctl_flag <= 1'b0;
            if (reg_wdata[4]) stop_cnt = 3;
            else if (resp_q.size() > 0) begin
               pend_st = resp_q.pop_front();
               lat_cnt = LAT;
            end
         end
      end
   end

   // write data source
   bit took = 0;
   always @(posedge clk) took = wdat_valid && wdat_ready;
   always @(negedge clk) begin
      if (took && wq.size() > 0) void'(wq.pop_front());
      took = 0;
      wdat_valid = (wq.size() > 0);
      wdat = (wq.size() > 0) ? wq[0] : 8'h00;
   end

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr) begin
            if (wexp_q.size() == 0)
               chk(0, {cur_req, " unexpected register write"}, {23'd0, reg_sel, reg_wdata}, 32'h0);
            else begin
               logic [8:0] e;
               e = wexp_q.pop_front();
               chk({reg_sel, reg_wdata} == e, {cur_req, " register write"}, {23'd0, reg_sel, reg_wdata}, {23'd0, e});
            end
         end
         if (rdat_valid) begin
            if (rd_q.size() == 0) chk(0, "R4 unexpected rdat", {24'd0, rdat}, 32'h0);
            else begin
               logic [7:0] r;
               r = rd_q.pop_front();
               chk(rdat == r, "R4 read byte", {24'd0, rdat}, {24'd0, r});
            end
         end
         if (done) begin
            if (res_q.size() == 0) chk(0, "R6 unexpected done", result, 32'h0);
            else begin
               logic [31:0] x;
               x = res_q.pop_front();
               chk(result == x, {cur_req, " result word"}, result, x);
            end
         end
      end
   end

   // watchdog
   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         miscompares++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         summary();
      end
   end

   task automatic txn(input logic [1:0] t_op, input logic [6:0] t_dev, input logic [31:0] t_ia,
                      input int t_ialen, input int t_cnt, input int bad, input int drop,
                      input bit stuck, input bit poke, input string req);
      int pw[$]; int pc[$]; int pe[$];
      int eff, last, k;
      bit hit_bad, hit_drop;
      logic [7:0] lst, s;
      logic [31:0] er;
      cur_req = req;
      eff = (t_ialen > 4) ? 4 : t_ialen;
      hit_bad = 0; hit_drop = 0; lst = 8'h00;
      pw.push_back(-1); pc.push_back('h60); pe.push_back('h08);
      if (t_op == 2'd0 || t_op == 2'd1) begin
         pw.push_back({t_dev, 1'b0}); pc.push_back('h40); pe.push_back('h18);
         for (int i = eff - 1; i >= 0; i--) begin
            pw.push_back(t_ia[8*i +: 8]); pc.push_back('h40); pe.push_back('h28);
         end
      end
      if (t_op == 2'd1) begin
         pw.push_back(-1); pc.push_back('h60); pe.push_back('h10);
         pw.push_back({t_dev, 1'b1}); pc.push_back('h40); pe.push_back('h40);
         for (int i = 0; i < t_cnt; i++) begin
            pw.push_back(-1);
            pc.push_back((i < t_cnt - 1) ? 'h44 : 'h40);
            pe.push_back((i < t_cnt - 1) ? 'h50 : 'h58);
         end
      end else if (t_op == 2'd0) begin
         for (int i = 0; i < t_cnt; i++) begin
            pw.push_back(8'hA0 + 8'(i)); pc.push_back('h40); pe.push_back('h28);
            wq.push_back(8'hA0 + 8'(i));
         end
      end else begin
         pw.push_back({t_dev, 1'b1}); pc.push_back('h40); pe.push_back('h40);
         pw.push_back(-1); pc.push_back('h40); pe.push_back('h58);
      end
      last = pe.size() - 1;
      for (k = 0; k < pe.size(); k++) begin
         if (k == drop) begin hit_drop = 1; last = k; break; end
         s = (k == bad) ? 8'h20 : 8'(pe[k]);
         resp_q.push_back(s);
         if (s == 8'h50 || s == 8'h58) begin
            rx_q.push_back(8'h30 + 8'(k));
            rd_q.push_back(8'h30 + 8'(k));
         end
         if (k == bad) begin hit_bad = 1; last = k; break; end
         lst = s;
      end
      for (int j = 0; j <= last; j++) begin
         if (pw[j] >= 0) wexp_q.push_back({1'b0, 8'(pw[j])});
         wexp_q.push_back({1'b1, 8'(pc[j])});
      end
      wexp_q.push_back({1'b1, 8'h50});
      if (hit_bad)       er = {8'h01, 8'(pc[last]) | 8'h08, 8'h20, 8'(pe[last])};
      else if (hit_drop) er = {8'h02, 8'(pc[last]), lst, 8'(pe[last])};
      else if (stuck)    er = {8'h02, 8'h50, lst, 8'hF8};
      else               er = 32'h0;
      res_q.push_back(er);
      stop_stuck = stuck;
      @(negedge clk);
      op = t_op; dev_addr = t_dev; ia = t_ia; ia_len = 3'(t_ialen); byte_cnt = 16'(t_cnt);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (5) @(negedge clk);
         op = 2'd2; start = 1'b1;
         @(negedge clk);
         start = 1'b0; op = t_op;
         chk(busy == 1'b1, "R10 start while busy keeps busy", {31'd0, busy}, 32'd1);
      end
      for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(wexp_q.size() == 0 && res_q.size() == 0, {req, " all writes and result seen, R9 stop"},
          wexp_q.size(), 0);
      wexp_q.delete(); res_q.delete(); resp_q.delete(); rx_q.delete(); rd_q.delete();
      wq.delete();
      stop_stuck = 0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(busy == 0 && done == 0 && result == 0 && reg_wr == 0, "R10 reset state",
          {busy, done, reg_wr, result[28:0]}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      txn(2'd0, 7'h50, 32'h0000_1234, 2, 3, -1, -1, 0, 0, "R1 write");
      txn(2'd1, 7'h51, 32'h0000_000F, 1, 3, -1, -1, 0, 0, "R3 read");
      txn(2'd1, 7'h22, 32'h0000_0077, 1, 1, -1, -1, 0, 0, "R4 single byte read");
      txn(2'd2, 7'h3C, 32'h0, 0, 0, -1, -1, 0, 0, "R5 probe");
      txn(2'd3, 7'h11, 32'h0, 0, 9, -1, -1, 0, 0, "R5 probe op3");
      txn(2'd1, 7'h19, 32'h0, 0, 0, -1, -1, 0, 0, "R12 read zero bytes");
      txn(2'd0, 7'h0A, 32'h0, 0, 0, -1, -1, 0, 0, "R12 write address only");
      txn(2'd0, 7'h6E, 32'hDEAD_BEEF, 4, 1, -1, -1, 0, 0, "R2 four byte address");
      txn(2'd0, 7'h6E, 32'hCAFE_F00D, 6, 2, -1, -1, 0, 0, "R2 clamped length");
      txn(2'd0, 7'h50, 32'h0000_0102, 2, 2, 1, -1, 0, 0, "R7 address mismatch");
      txn(2'd0, 7'h50, 32'h0000_0102, 2, 3, 4, -1, 0, 0, "R7 data mismatch");
      txn(2'd1, 7'h51, 32'h0000_00AB, 1, 2, -1, 2, 0, 0, "R8 timeout");
      txn(2'd0, 7'h33, 32'h0000_0044, 1, 1, -1, -1, 1, 0, "R9 stop timeout");
      txn(2'd0, 7'h33, 32'h0000_0044, 1, 1, 1, -1, 1, 0, "R9 earlier error kept");
      txn(2'd0, 7'h45, 32'h0000_5566, 2, 4, -1, -1, 0, 1, "R10 start ignored, R11 data order");
      txn(2'd0, 7'h12, 32'h0, 0, 0, -1, -1, 0, 0, "R6 success word");
      summary();
   end

endmodule